// File: doc/BRIEF.md
# UART Register Front End

This block sits between a 32-bit register bus and the byte-level cores of a simple serial port. It holds one byte waiting to be sent and one byte that has been received. Software reads the state of both slots through a single data word. One bit tells whether the transmit slot is free, and another tells whether a received byte is waiting. Writes to that same word queue a byte for sending and release a received byte.

A second word holds the line configuration: a two-bit interface-mode field, a transmit-ready override and a receive-ready override. These values are driven straight out to the line logic. The same word also carries a sticky overrun bit, which is set when a byte arrives while the previous one has not yet been released.

The transmitter core takes bytes through a valid/ready handshake. The receiver core presents each byte as a one-cycle strobe and cannot be stalled.

Top module: `uart_csr_front`

## Requirements
- R1: A read request (`bus_sel`=1, `bus_wr`=0) returns its word on `bus_rdata` in the following cycle. In every cycle that does not follow a read request, `bus_rdata` is 0.
- R2: The data word is at offset 0x0. Bits 7:0 hold the last received byte, bit 8 is 1 while a received byte is waiting, and bit 9 is 1 while the transmit slot is free. All other bits read 0. A `rx_strobe` while no byte is waiting captures `rx_data` and sets bit 8.
- R3: Writing the data word with bit 8 set releases the waiting byte and clears bit 8. Writing it with bit 8 clear leaves bit 8 unchanged. The byte field keeps its last value after a release.
- R4: Writing the data word with bit 9 set while the slot is free loads bits 7:0 onto `tx_data` and raises `tx_valid` in the next cycle. Read bit 9 stays 0 until a cycle with `tx_valid` and `tx_ready` both high, after which `tx_valid` falls.
- R5: A data-word write with bit 9 clear starts no transmission. A write with bit 9 set while a byte is still pending is ignored and leaves `tx_data` unchanged.
- R6: A data-word write with bits 8 and 9 both set performs both the release and the transmit load in the same cycle.
- R7: A `rx_strobe` while a byte is waiting, with no release in that cycle, keeps the held byte and sets the overrun bit, which is bit 9 of the control word. The overrun bit is cleared by writing 1 to that bit, and it is set rather than cleared if both happen in the same cycle.
- R8: The control word is at offset 0x4. Bits 3:2 are the interface mode (1 = DTE, 2 = DCE), bit 7 is the transmit-ready override and bit 8 is the receive-ready override. A write updates the readback and `if_mode`, `tx_rdy_ovrd` and `rx_rdy_ovrd` in the next cycle.
- R9: Reads have no side effect on either slot or on the overrun bit.
- R10: After reset the data word reads 0x200, the control word reads 0, `tx_valid` is 0 and all control outputs are 0.
- R11: A release and a `rx_strobe` in the same cycle capture the new byte, leave bit 8 at 1 and do not set the overrun bit.
- R12: Offsets other than 0x0 and 0x4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tx_valid | output | 1 | A byte is pending for the transmitter |
| tx_data | output | BYTE_W | Pending transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| rx_strobe | input | 1 | Receiver delivers a byte this cycle |
| rx_data | input | BYTE_W | Received byte |
| if_mode | output | 2 | Interface mode to the line logic |
| tx_rdy_ovrd | output | 1 | Transmit-ready override |
| rx_rdy_ovrd | output | 1 | Receive-ready override |

## Verification
A wrong slot state shows on the ports no later than one cycle after the next read of the data word. A wrong transmit state shows even earlier, on `tx_valid` and `tx_data` in the cycle after the write. A lost overrun or a wrong mode field appears one cycle after a read of the control word, and a wrong mode also shows on the control outputs as soon as it is written. The bench runs a behavioural model beside the design and compares every output on every clock. It also makes directed reads with fixed expected words for each corner: release together with arrival, a load while busy, a combined release and load, and unmapped offsets.

// File: rtl/uart_csr_pkg.sv
`timescale 1ns/1ps
package uart_csr_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CTL  = 4;
  localparam int unsigned MODE_LSB = 2;
  localparam int unsigned TXO_BIT  = 7;
  localparam int unsigned RXO_BIT  = 8;
  localparam int unsigned OVR_BIT  = 9;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DTE  = 2'd1,
    MODE_DCE  = 2'd2,
    MODE_RSVD = 2'd3
  } if_mode_e;

  typedef struct packed {
    if_mode_e mode;
    logic     tx_ovrd;
    logic     rx_ovrd;
    logic     overrun;
  } ctl_t;
endpackage

// File: rtl/uart_tx_slot.sv
`timescale 1ns/1ps
module uart_tx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              core_ready,
  output logic              busy,
  output logic [BYTE_W-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      byte_q <= '0;
    end else if (busy && core_ready) begin
      busy <= 1'b0;
    end else if (!busy && load) begin
      busy   <= 1'b1;
      byte_q <= load_byte;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !core_ready) |=> (busy && $stable(byte_q))); // R5
  AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
    (busy && core_ready) |=> !busy); // R4
endmodule

// File: rtl/uart_rx_slot.sv
`timescale 1ns/1ps
module uart_rx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              release_req,
  output logic              full,
  output logic [BYTE_W-1:0] byte_q,
  output logic              ovr_evt
);
  logic take;
  assign take    = strobe && (!full || release_req);
  assign ovr_evt = strobe && full && !release_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      byte_q <= '0;
    end else if (take) begin
      full   <= 1'b1;
      byte_q <= in_byte;
    end else if (release_req) begin
      full <= 1'b0;
    end
  end

  AST_RX_KEEP: assert property (@(posedge clk) disable iff (rst)
    (full && strobe && !release_req) |=> (full && $stable(byte_q))); // R7
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (release_req && !strobe) |=> !full); // R3
  AST_RX_SWAP: assert property (@(posedge clk) disable iff (rst)
    (full && strobe && release_req) |=> (full && byte_q == $past(in_byte))); // R11
endmodule

// File: rtl/uart_ctl_reg.sv
`timescale 1ns/1ps
module uart_ctl_reg
  import uart_csr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  if_mode_e wr_mode,
  input  logic     wr_tx_ovrd,
  input  logic     wr_rx_ovrd,
  input  logic     wr_ovr_clr,
  input  logic     ovr_evt,
  output ctl_t     ctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '{mode: MODE_OFF, tx_ovrd: 1'b0, rx_ovrd: 1'b0, overrun: 1'b0};
    end else begin
      if (wr) begin
        ctl.mode    <= wr_mode;
        ctl.tx_ovrd <= wr_tx_ovrd;
        ctl.rx_ovrd <= wr_rx_ovrd;
      end
      if (ovr_evt)                 ctl.overrun <= 1'b1;
      else if (wr && wr_ovr_clr)   ctl.overrun <= 1'b0;
    end
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> ctl.overrun); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ctl.mode == $past(wr_mode))); // R8
endmodule

// File: rtl/uart_csr_front.sv
`timescale 1ns/1ps
module uart_csr_front
  import uart_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_data,
  output logic [1:0]        if_mode,
  output logic              tx_rdy_ovrd,
  output logic              rx_rdy_ovrd
);
  localparam int unsigned RXF_BIT = BYTE_W;
  localparam int unsigned TXF_BIT = BYTE_W + 1;
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);

  logic hit_data, hit_ctl, rd_req;
  logic tx_load, rx_release, ctl_wr;
  logic tx_busy, rx_full, ovr_evt;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  ctl_t ctl;
  logic [DATA_W-1:0] data_word, ctl_word;
  logic unused_wbits;

  assign hit_data   = bus_sel && (bus_addr == A_DATA);
  assign hit_ctl    = bus_sel && (bus_addr == A_CTL);
  assign rd_req     = bus_sel && !bus_wr;
  assign tx_load    = hit_data && bus_wr && bus_wdata[TXF_BIT];
  assign rx_release = hit_data && bus_wr && bus_wdata[RXF_BIT];
  assign ctl_wr     = hit_ctl && bus_wr;
  assign unused_wbits = ^bus_wdata[DATA_W-1:TXF_BIT+1];

  uart_tx_slot #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_byte(bus_wdata[BYTE_W-1:0]),
    .core_ready(tx_ready), .busy(tx_busy), .byte_q(tx_byte)
  );

  uart_rx_slot #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .strobe(rx_strobe), .in_byte(rx_data),
    .release_req(rx_release), .full(rx_full), .byte_q(rx_byte), .ovr_evt(ovr_evt)
  );

  uart_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr),
    .wr_mode(if_mode_e'(bus_wdata[MODE_LSB +: 2])),
    .wr_tx_ovrd(bus_wdata[TXO_BIT]), .wr_rx_ovrd(bus_wdata[RXO_BIT]),
    .wr_ovr_clr(bus_wdata[OVR_BIT]), .ovr_evt(ovr_evt), .ctl(ctl)
  );

  always_comb begin
    data_word = '0;
    data_word[BYTE_W-1:0] = rx_byte;
    data_word[RXF_BIT]    = rx_full;
    data_word[TXF_BIT]    = !tx_busy;
    ctl_word = '0;
    ctl_word[MODE_LSB +: 2] = ctl.mode;
    ctl_word[TXO_BIT]       = ctl.tx_ovrd;
    ctl_word[RXO_BIT]       = ctl.rx_ovrd;
    ctl_word[OVR_BIT]       = ctl.overrun;
  end

  always_ff @(posedge clk) begin
    if (rst)                        bus_rdata <= '0;
    else if (rd_req && hit_data)    bus_rdata <= data_word;
    else if (rd_req && hit_ctl)     bus_rdata <= ctl_word;
    else                            bus_rdata <= '0;
  end

  assign tx_valid    = tx_busy;
  assign tx_data     = tx_byte;
  assign if_mode     = ctl.mode;
  assign tx_rdy_ovrd = ctl.tx_ovrd;
  assign rx_rdy_ovrd = ctl.rx_ovrd;

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (bus_rdata == '0)); // R1
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rx_strobe) |=> ($stable(rx_full) && $stable(rx_byte))); // R9
  AST_LOAD_SEEN: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !tx_busy) |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0]))); // R4
endmodule

// File: tb/uart_csr_front_bench.sv
`timescale 1ns/1ps
module uart_csr_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_strobe = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [1:0]  if_mode;
  logic        tx_rdy_ovrd, rx_rdy_ovrd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  uart_csr_front u_uart_csr_front (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_strobe(rx_strobe), .rx_data(rx_data), .if_mode(if_mode),
    .tx_rdy_ovrd(tx_rdy_ovrd), .rx_rdy_ovrd(rx_rdy_ovrd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_txbusy, m_txbyte, m_rxfull, m_rxbyte, m_mode, m_txo, m_rxo, m_ovr, m_rdata;
  always @(posedge clk) begin
    int rd, rel, ld, ovr;
    if (rst) begin
      m_txbusy = 0; m_txbyte = 0; m_rxfull = 0; m_rxbyte = 0;
      m_mode = 0; m_txo = 0; m_rxo = 0; m_ovr = 0; m_rdata = 0;
    end else begin
      rd = 0;
      if (bus_sel && !bus_wr) begin
        if (bus_addr == 0) rd = (m_txbusy ? 0 : 512) + (m_rxfull ? 256 : 0) + m_rxbyte;
        else if (bus_addr == 4) rd = (m_mode << 2) + (m_txo << 7) + (m_rxo << 8) + (m_ovr << 9);
      end
      m_rdata = rd;
      rel = (bus_sel && bus_wr && bus_addr == 0 && bus_wdata[8]) ? 1 : 0;
      ld  = (bus_sel && bus_wr && bus_addr == 0 && bus_wdata[9]) ? 1 : 0;
      ovr = (rx_strobe && m_rxfull && !rel) ? 1 : 0;
      if (m_txbusy && tx_ready) m_txbusy = 0;
      else if (!m_txbusy && ld) begin m_txbusy = 1; m_txbyte = int'(bus_wdata[7:0]); end
      if (rx_strobe && (!m_rxfull || rel)) begin m_rxfull = 1; m_rxbyte = int'(rx_data); end
      else if (rel) m_rxfull = 0;
      if (ovr) m_ovr = 1;
      else if (bus_sel && bus_wr && bus_addr == 4 && bus_wdata[9]) m_ovr = 0;
      if (bus_sel && bus_wr && bus_addr == 4) begin
        m_mode = int'(bus_wdata[3:2]); m_txo = int'(bus_wdata[7]); m_rxo = int'(bus_wdata[8]);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(bus_rdata == 32'(m_rdata), "R1 model rdata", bus_rdata, 32'(m_rdata));
      chk(tx_valid == m_txbusy[0], "R4 model tx_valid", 32'(tx_valid), 32'(m_txbusy));
      chk(tx_data == m_txbyte[7:0], "R5 model tx_data", 32'(tx_data), 32'(m_txbyte));
      chk(if_mode == m_mode[1:0] && tx_rdy_ovrd == m_txo[0] && rx_rdy_ovrd == m_rxo[0],
          "R8 model ctl outputs", {if_mode, tx_rdy_ovrd, rx_rdy_ovrd}, 32'(m_mode*4 + m_txo*2 + m_rxo));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    rx_strobe = 1; rx_data = b;
    @(negedge clk);
    rx_strobe = 0;
  endtask

  task automatic tx_take();
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL R1 watchdog actual=%0d cycles expected=done", WATCHDOG);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(tx_valid == 0 && if_mode == 0 && !tx_rdy_ovrd && !rx_rdy_ovrd, "R10 reset outputs",
        {tx_valid, if_mode, tx_rdy_ovrd, rx_rdy_ovrd}, 0);
    rd(4'h0, 32'h200, "R10 data word after reset");
    rd(4'h4, 32'h000, "R10 control word after reset");

    wr(4'h4, 32'h188);
    chk(if_mode == 2 && tx_rdy_ovrd && rx_rdy_ovrd, "R8 DCE and overrides out",
        {if_mode, tx_rdy_ovrd, rx_rdy_ovrd}, 32'h0b);
    rd(4'h4, 32'h188, "R8 control readback");
    wr(4'h4, 32'h004);
    chk(if_mode == 1 && !tx_rdy_ovrd && !rx_rdy_ovrd, "R8 DTE out",
        {if_mode, tx_rdy_ovrd, rx_rdy_ovrd}, 32'h04);

    wr(4'h0, 32'h041);
    chk(tx_valid == 0, "R5 write without bit 9", 32'(tx_valid), 0);
    rd(4'h0, 32'h200, "R5 slot still free");
    wr(4'h0, 32'h241);
    chk(tx_valid == 1 && tx_data == 8'h41, "R4 load", {tx_valid, tx_data}, 32'h141);
    rd(4'h0, 32'h000, "R4 ready flag low while pending");
    wr(4'h0, 32'h255);
    chk(tx_data == 8'h41, "R5 load while busy ignored", 32'(tx_data), 32'h41);
    tx_take();
    chk(tx_valid == 0, "R4 handshake drops valid", 32'(tx_valid), 0);
    rd(4'h0, 32'h200, "R4 ready flag back");

    rx_byte(8'hA5);
    rd(4'h0, 32'h3A5, "R2 byte captured");
    rd(4'h0, 32'h3A5, "R9 second read unchanged");
    wr(4'h0, 32'h000);
    rd(4'h0, 32'h3A5, "R3 bit 8 clear keeps byte");
    rx_byte(8'h3C);
    rd(4'h0, 32'h3A5, "R7 held byte kept");
    rd(4'h4, 32'h204, "R7 overrun set");
    rd(4'h4, 32'h204, "R9 control read no side effect");
    wr(4'h4, 32'h204);
    rd(4'h4, 32'h004, "R7 overrun cleared");
    wr(4'h0, 32'h100);
    rd(4'h0, 32'h2A5, "R3 release");

    rx_byte(8'h11);
    wr(4'h0, 32'h3EE);
    chk(tx_valid == 1 && tx_data == 8'hEE, "R6 combined load", {tx_valid, tx_data}, 32'h1EE);
    rd(4'h0, 32'h011, "R6 combined release");
    tx_take();

    rx_byte(8'h22);
    rx_strobe = 1; rx_data = 8'h77;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 32'h100;
    @(negedge clk);
    rx_strobe = 0; bus_sel = 0; bus_wr = 0;
    rd(4'h0, 32'h377, "R11 release with arrival");
    rd(4'h4, 32'h004, "R11 no overrun");

    wr(4'h8, 32'h3FF);
    rd(4'h4, 32'h004, "R12 control untouched");
    rd(4'h0, 32'h377, "R12 data untouched");
    chk(tx_valid == 0, "R12 no transmit", 32'(tx_valid), 0);
    rd(4'h8, 32'h000, "R12 unmapped reads zero");
    rd(4'hC, 32'h000, "R12 unmapped reads zero");
    @(negedge clk);
    chk(bus_rdata == 0, "R1 idle rdata zero", bus_rdata, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule